// File: doc/BRIEF.md
# Size-Aware Register-to-Register Execute Unit

This block holds a bank of sixteen 20-bit general registers and executes one register-to-register operation per accepted cycle. An instruction names a source register, a destination register, an operation and an operand size. Both operands are cut down to the chosen size, the operation is evaluated on those low bits, and the destination is written with its bits above the operand size forced to zero. Sign extension is the only operation that fills those upper bits, copying bit 7 of the destination upward. A separate combinational read port exposes any register for observation, and an immediate operation seeds registers from an input value.

The unit fits under a decoder that has already split an instruction into fields. There are no flags, no memory operands and no special register roles: every register behaves the same way.

Top module: `reg_exec_unit`

## Requirements
- R1: While `rst_ni` is low, all sixteen registers read as zero, without waiting for a clock edge.
- R2: Size `00` (byte) uses only bits 7:0 of the operands and writes a destination whose bits 19:8 are zero.
- R3: Size `01` (word) uses only bits 15:0 of the operands and writes a destination whose bits 19:16 are zero.
- R4: Size `10` (address-word) uses and writes all 20 bits.
- R5: Operation codes are 000 copy source, 001 dst+src, 010 dst-src, 011 dst AND src, 100 dst OR src, 101 dst XOR src, 111 copy `imm_i`. Addition and subtraction wrap within the selected size.
- R6: Code 110 (sign extend) writes destination bits 7:0 unchanged and fills bits 19:8 with destination bit 7, for sizes 00, 01 and 10 alike. The source is not used.
- R7: Size `11` performs no write for any operation.
- R8: Only the destination changes on an accepted write. The source keeps its value unless it is also the destination, in which case its old value is the operand.
- R9: With `valid_i` low, no register changes at the clock edge.
- R10: `rd_data_o` follows `rd_addr_i` combinationally and shows a write from the clock edge that performed it onward.
- R11: A word OR of a source holding 0xAA550 into a destination holding 0x11111 leaves 0x0B551.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction accepted on this edge |
| op_i | input | 3 | Operation code |
| size_i | input | 2 | Operand size code |
| src_i | input | 4 | Source register index |
| dst_i | input | 4 | Destination register index |
| imm_i | input | 20 | Immediate operand for code 111 |
| rd_addr_i | input | 4 | Observation read index |
| rd_data_o | output | 20 | Observation read data |

## Verification
The hardest case is a destination whose upper bits were nonzero before a narrow write, since clearing them can be missed when registers only ever hold small values. The stimulus therefore seeds both registers with full 20-bit patterns through the immediate path before every operation, sweeping every operation and size over patterns with bit 7, bit 15 and bit 19 in both states, and index pairs that include source equal to destination.

// File: rtl/reg_exec_pkg.sv
package reg_exec_pkg;
  typedef enum logic [2:0] {
    OP_MOV  = 3'd0,
    OP_ADD  = 3'd1,
    OP_SUB  = 3'd2,
    OP_AND  = 3'd3,
    OP_OR   = 3'd4,
    OP_XOR  = 3'd5,
    OP_SXT  = 3'd6,
    OP_MOVI = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_ADDR = 2'd2,
    SZ_NONE = 2'd3
  } size_e;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
endpackage

// File: rtl/reg_exec_regfile.sv
module reg_exec_regfile #(
  parameter int NUM_REGS = 16,
  parameter int REG_W    = 20,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] src_addr_i,
  input  logic [ADDR_W-1:0] dst_addr_i,
  input  logic [ADDR_W-1:0] dbg_addr_i,
  output logic [REG_W-1:0]  src_data_o,
  output logic [REG_W-1:0]  dst_data_o,
  output logic [REG_W-1:0]  dbg_data_o
);
  logic [NUM_REGS-1:0][REG_W-1:0] mem_q;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    mem_q[g] <= '0;
      else if (wr_en_i && wr_addr_i == ADDR_W'(g))    mem_q[g] <= wr_data_i;
    end

    AST_OTHERS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && wr_addr_i == ADDR_W'(g)) |=> $stable(mem_q[g])); // R8
  end

  assign src_data_o = mem_q[src_addr_i];
  assign dst_data_o = mem_q[dst_addr_i];
  assign dbg_data_o = mem_q[dbg_addr_i];

  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> mem_q[$past(wr_addr_i)] == $past(wr_data_i)); // R4
endmodule

// File: rtl/reg_exec_alu.sv
module reg_exec_alu
  import reg_exec_pkg::*;
#(
  parameter int REG_W = 20
) (
  input  op_e              op_i,
  input  size_e            size_i,
  input  logic [REG_W-1:0] src_val_i,
  input  logic [REG_W-1:0] dst_val_i,
  input  logic [REG_W-1:0] imm_i,
  output logic [REG_W-1:0] raw_o
);
  logic [REG_W-1:0] mask, a_sel, a, b;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: mask = REG_W'({BYTE_W{1'b1}});
      SZ_WORD: mask = REG_W'({WORD_W{1'b1}});
      default: mask = '1;
    endcase
  end

  assign a_sel = (op_i == OP_MOVI) ? imm_i : src_val_i;
  assign a     = a_sel & mask;
  assign b     = dst_val_i & mask;

  always_comb begin
    unique case (op_i)
      OP_MOV,
      OP_MOVI: raw_o = a;
      OP_ADD:  raw_o = b + a;
      OP_SUB:  raw_o = b - a;
      OP_AND:  raw_o = b & a;
      OP_OR:   raw_o = b | a;
      OP_XOR:  raw_o = b ^ a;
      default: raw_o = dst_val_i; // sign extend works on destination
    endcase
  end
endmodule

// File: rtl/reg_exec_writeback.sv
module reg_exec_writeback
  import reg_exec_pkg::*;
#(
  parameter int REG_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  op_e              op_i,
  input  size_e            size_i,
  input  logic [REG_W-1:0] raw_i,
  output logic             wr_en_o,
  output logic [REG_W-1:0] wr_data_o
);
  localparam int UPPER_W = REG_W - BYTE_W;

  logic [REG_W-1:0] keep_mask;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: keep_mask = REG_W'({BYTE_W{1'b1}});
      SZ_WORD: keep_mask = REG_W'({WORD_W{1'b1}});
      default: keep_mask = '1;
    endcase
  end

  assign wr_en_o   = valid_i && (size_i != SZ_NONE);
  assign wr_data_o = (op_i == OP_SXT) ? {{UPPER_W{raw_i[BYTE_W-1]}}, raw_i[BYTE_W-1:0]}
                                      : (raw_i & keep_mask);

  AST_BYTE_UPPER_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o && size_i == SZ_BYTE && op_i != OP_SXT |-> wr_data_o[REG_W-1:BYTE_W] == '0); // R2
  AST_WORD_UPPER_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o && size_i == SZ_WORD && op_i != OP_SXT |-> wr_data_o[REG_W-1:WORD_W] == '0); // R3
  AST_SXT_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o && op_i == OP_SXT |-> wr_data_o[REG_W-1:BYTE_W] == {UPPER_W{raw_i[BYTE_W-1]}}); // R6
  AST_NO_SIZE_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    size_i == SZ_NONE |-> !wr_en_o); // R7
  AST_IDLE_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !wr_en_o); // R9
endmodule

// File: rtl/reg_exec_unit.sv
module reg_exec_unit
  import reg_exec_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int REG_W    = 20,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [REG_W-1:0]  imm_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o
);
  op_e              op;
  size_e            size;
  logic [REG_W-1:0] src_val, dst_val, raw, wr_data;
  logic             wr_en;

  assign op   = op_e'(op_i);
  assign size = size_e'(size_i);

  reg_exec_regfile #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) regfile_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_addr_i  (dst_i),
    .wr_data_i  (wr_data),
    .src_addr_i (src_i),
    .dst_addr_i (dst_i),
    .dbg_addr_i (rd_addr_i),
    .src_data_o (src_val),
    .dst_data_o (dst_val),
    .dbg_data_o (rd_data_o)
  );

  reg_exec_alu #(.REG_W(REG_W)) alu_i (
    .op_i      (op),
    .size_i    (size),
    .src_val_i (src_val),
    .dst_val_i (dst_val),
    .imm_i     (imm_i),
    .raw_o     (raw)
  );

  reg_exec_writeback #(.REG_W(REG_W)) wb_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .op_i      (op),
    .size_i    (size),
    .raw_i     (raw),
    .wr_en_o   (wr_en),
    .wr_data_o (wr_data)
  );
endmodule

// File: tb/reg_exec_unit_tb.sv
module reg_exec_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [2:0]  op = '0;
  logic [1:0]  size = '0;
  logic [3:0]  src = '0, dst = '0, rd_addr = '0;
  logic [19:0] imm = '0;
  logic [19:0] rd_data;

  int checks = 0;
  int fails  = 0;
  logic [19:0] model [16];
  bit done = 1'b0;

  always #4 clk = ~clk;

  reg_exec_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .size_i(size),
    .src_i(src), .dst_i(dst), .imm_i(imm), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  function automatic logic [19:0] sz_mask(logic [1:0] s);
    case (s)
      2'd0:    return 20'h000FF;
      2'd1:    return 20'h0FFFF;
      default: return 20'hFFFFF;
    endcase
  endfunction

  function automatic logic [19:0] expect_val(logic [2:0] o, logic [1:0] s,
                                             logic [19:0] sv, logic [19:0] dv, logic [19:0] iv);
    logic [19:0] m, a, b;
    m = sz_mask(s); a = sv & m; b = dv & m;
    case (o)
      3'd0: return a;
      3'd1: return (b + a) & m;
      3'd2: return (b - a) & m;
      3'd3: return b & a;
      3'd4: return b | a;
      3'd5: return b ^ a;
      3'd6: return {{12{dv[7]}}, dv[7:0]};
      default: return iv & m;
    endcase
  endfunction

  function automatic string tag_for(logic [2:0] o, logic [1:0] s);
    if (s == 2'd3) return "R7";
    if (o == 3'd6) return "R6";
    if (s == 2'd0) return "R2";
    if (s == 2'd1) return "R3";
    return "R4";
  endfunction

  task automatic check(input logic [3:0] a, input logic [19:0] exp, input string tag);
    rd_addr = a;
    #1;
    checks++;
    if (rd_data !== exp) begin
      fails++;
      $display("FAIL %s reg=%0d actual=%h expected=%h", tag, a, rd_data, exp);
    end
  endtask

  task automatic issue(input logic [2:0] o, input logic [1:0] s, input logic [3:0] sr,
                       input logic [3:0] ds, input logic [19:0] iv);
    @(negedge clk);
    op = o; size = s; src = sr; dst = ds; imm = iv; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    if (s != 2'd3) model[ds] = expect_val(o, s, model[sr], model[ds], iv);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [19:0] pats [7];
    logic [3:0]  ri, rj;
    int          n;
    pats = '{20'h00000, 20'hFFFFF, 20'hAA550, 20'h11111, 20'h0017F, 20'h80080, 20'h7FF80};
    for (int k = 0; k < 16; k++) model[k] = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    for (int k = 0; k < 16; k++) check(4'(k), 20'h0, "R1");
    rst_n = 1'b1;

    // R11: worked OR example
    issue(3'd7, 2'd2, 4'd0, 4'd5, 20'hAA550);
    issue(3'd7, 2'd2, 4'd0, 4'd6, 20'h11111);
    issue(3'd4, 2'd1, 4'd5, 4'd6, 20'h0);
    check(4'd6, 20'h0B551, "R11");
    check(4'd5, 20'hAA550, "R8");

    // R10: read port follows address with no clock edge
    @(negedge clk);
    check(4'd5, 20'hAA550, "R10");
    check(4'd6, 20'h0B551, "R10");

    // R9: fields set but valid low
    @(negedge clk);
    op = 3'd7; size = 2'd2; dst = 4'd6; imm = 20'h12345; valid = 1'b0;
    @(negedge clk);
    check(4'd6, 20'h0B551, "R9");

    // R5: immediate load honours size
    issue(3'd7, 2'd0, 4'd0, 4'd7, 20'hFFFFF);
    check(4'd7, 20'h000FF, "R5");

    // Sweep: every operation, size and operand pattern
    n = 0;
    for (int o = 0; o < 7; o++)
      for (int s = 0; s < 4; s++)
        for (int p = 0; p < 7; p++)
          for (int q = 0; q < 7; q++) begin
            ri = 4'(n % 16);
            rj = 4'((n * 7 + 3) % 16);
            n++;
            issue(3'd7, 2'd2, 4'd0, ri, pats[p]);
            issue(3'd7, 2'd2, 4'd0, rj, pats[q]);
            issue(3'(o), 2'(s), ri, rj, 20'h5A5A5);
            check(rj, model[rj], tag_for(3'(o), 2'(s)));
            if (ri != rj) check(ri, model[ri], "R8");
            check(4'(rj + 4'd1), model[4'(rj + 4'd1)], "R8");
          end

    // R5: wrap of add and subtract at each size
    issue(3'd7, 2'd2, 4'd0, 4'd1, 20'h000FF);
    issue(3'd7, 2'd2, 4'd0, 4'd2, 20'h00001);
    issue(3'd1, 2'd0, 4'd2, 4'd1, 20'h0);
    check(4'd1, 20'h00000, "R5");
    issue(3'd2, 2'd1, 4'd2, 4'd1, 20'h0);
    check(4'd1, 20'h0FFFF, "R5");
    issue(3'd7, 2'd2, 4'd0, 4'd1, 20'hFFFFF);
    issue(3'd1, 2'd2, 4'd2, 4'd1, 20'h0);
    check(4'd1, 20'h00000, "R5");

    // R6: sign extend with negative low byte
    issue(3'd7, 2'd2, 4'd0, 4'd3, 20'h00080);
    issue(3'd6, 2'd0, 4'd9, 4'd3, 20'h0);
    check(4'd3, 20'hFFF80, "R6");

    // R1: asynchronous reset mid-run
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1;
    for (int k = 0; k < 16; k++) check(4'(k), 20'h0, "R1");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule